// File: doc/BRIEF.md
# DRAM Refresh and Address Multiplex Controller

This controller connects a processor bus to two banks of 256K x 16 dynamic memory. A processor access presents a byte address and a read/write flag. The controller takes the 18-bit word address (byte address bits 18 down to 1) and splits it into a 9-bit row half and a 9-bit column half. It drives the two halves one after the other onto a shared 9-bit multiplexed address bus. The row strobe of the selected bank latches the row half, and that bank's column strobe then latches the column half. The bank is chosen by one address bit above the word address.

A free-running timer raises a refresh request once every `REF_INTERVAL` clock cycles. The controller serves each request with a RAS-only cycle: both banks' row strobes go low together, the address bus carries an 8-bit row counter, and the column strobes stay high. A request that arrives during a processor access waits until that access has finished. A waiting refresh is served before any new processor request. While a refresh is running, or while a processor request is still outstanding, `wait_o` holds the processor off. Each phase of the access and refresh sequences lasts a number of cycles set by a parameter.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: During a processor access the multiplexed address `ma_o` carries `addr_i[18:10]` while the row strobe is low and the column strobe is high. It carries `addr_i[9:1]` while the column strobe is low.
- R2: For the selected bank, the row strobe falls before the column strobe. The column strobe is low only while that bank's row strobe is low. When the access is acknowledged, all strobes are high.
- R3: `we_n_o` is low during the column phase of a write and high during the column phase of a read.
- R4: A refresh drives both row strobes low at once. Both column strobes stay high and `we_n_o` stays high. `ma_o` equals the refresh row counter, zero-extended to 9 bits.
- R5: `addr_i[19]` selects the bank: 0 selects bank 0 (strobe bit 0) and 1 selects bank 1 (strobe bit 1). During an access, the strobes of the other bank stay high.
- R6: `wait_o` is high while a refresh is running. It is also high while `req_i` is asserted and the access has not been acknowledged. `ack_o` is high for exactly one cycle at the end of an access, and `wait_o` is low in that cycle.
- R7: A refresh that comes due during a processor access starts only after that access has been acknowledged. A pending refresh is served before a request that is already waiting.
- R8: When no processor access is in the way, consecutive refreshes start exactly `REF_INTERVAL` clock cycles apart.
- R9: The refresh row counter is 0 after reset. It increments by one after each refresh and wraps from 255 to 0.
- R10: During reset, every strobe and `we_n_o` is high, and `wait_o` and `ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor access request, held until `ack_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (20) | Processor byte address |
| wait_o | output | 1 | Processor must wait |
| ack_o | output | 1 | One-cycle pulse at the end of an access |
| ma_o | output | MA_W (9) | Multiplexed DRAM address |
| ras_n_o | output | BANKS (2) | Row strobe per bank, active low |
| cas_n_o | output | BANKS (2) | Column strobe per bank, active low |
| we_n_o | output | 1 | DRAM write enable, active low |

## Verification
The bench times one access so that the refresh timer expires halfway through it, and keeps the next request asserted as soon as the access is acknowledged. A controller without correct priority would either cut into the access with a refresh or let the waiting access run ahead of the pending refresh. The bench lets the row counter run through more than 256 refreshes, which catches a counter that saturates or fails to wrap back to 0. It also compares the spacing between idle refreshes against the interval, which exposes an off-by-one reload of the timer. Accesses to both banks with both read and write confirm that each half of the address appears under the right strobe and that an access to one bank never disturbs the other.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_DONE,
    ST_REF_RAS,
    ST_REF_DONE
  } seq_state_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int REF_INTERVAL = 780,
  parameter int ROW_W        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             done_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CNT_W = $clog2(REF_INTERVAL + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(REF_INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RELOAD;
    else if (expire) cnt_q <= RELOAD;
    else cnt_q <= cnt_q - 1'b1;
  end

  // expiry wins over a same-cycle take so no interval is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else if (expire) pend_o <= 1'b1;
    else if (take_i) pend_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_o <= '0;
    else if (done_i) row_o <= row_o + 1'b1;
  end

  assert_pend_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !take_i) |=> pend_o);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int T_ROW      = 2,
  parameter int T_COL      = 2,
  parameter int T_DONE     = 2,
  parameter int T_REF_RAS  = 3,
  parameter int T_REF_DONE = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       ref_pend_i,
  output seq_state_e state_o,
  output logic       latch_o,
  output logic       ref_take_o,
  output logic       ref_done_o,
  output logic       ack_o
);
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX  = max2(max2(max2(T_ROW, T_COL), max2(T_DONE, T_REF_RAS)), T_REF_DONE);
  localparam int CNT_W = $clog2(TMAX + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] ph_q, ph_d;
  logic             last;

  assign last    = (ph_q == '0);
  assign state_o = state_q;

  always_comb begin
    state_d    = state_q;
    ph_d       = last ? '0 : ph_q - 1'b1;
    latch_o    = 1'b0;
    ref_take_o = 1'b0;
    ref_done_o = 1'b0;
    ack_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend_i) begin
          state_d    = ST_REF_RAS;
          ph_d       = CNT_W'(T_REF_RAS - 1);
          ref_take_o = 1'b1;
        end else if (req_i) begin
          state_d = ST_ROW;
          ph_d    = CNT_W'(T_ROW - 1);
          latch_o = 1'b1;
        end
      end
      ST_ROW: if (last) begin
        state_d = ST_COL;
        ph_d    = CNT_W'(T_COL - 1);
      end
      ST_COL: if (last) begin
        state_d = ST_DONE;
        ph_d    = CNT_W'(T_DONE - 1);
      end
      ST_DONE: if (last) begin
        state_d = ST_IDLE;
        ack_o   = 1'b1;
      end
      ST_REF_RAS: if (last) begin
        state_d = ST_REF_DONE;
        ph_d    = CNT_W'(T_REF_DONE - 1);
      end
      ST_REF_DONE: if (last) begin
        state_d    = ST_IDLE;
        ref_done_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
    end
  end

  assert_ref_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ref_pend_i) |=> (state_q == ST_REF_RAS));
  assert_access_uninterrupted_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ROW) |=> (state_q inside {ST_ROW, ST_COL}));
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int MA_W     = 9,
  parameter int BANK_LSB = 19,
  parameter int BANK_W   = 1,
  parameter int ROW_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  seq_state_e        state_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  output logic [MA_W-1:0]   ma_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              we_o
);
  localparam int COL_LSB = 1;
  localparam int ROW_LSB = COL_LSB + MA_W;

  logic [MA_W-1:0] row_q, col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      bank_o <= '0;
      we_o   <= 1'b0;
    end else if (latch_i) begin
      row_q  <= addr_i[ROW_LSB +: MA_W];
      col_q  <= addr_i[COL_LSB +: MA_W];
      bank_o <= addr_i[BANK_LSB +: BANK_W];
      we_o   <= we_i;
    end
  end

  always_comb begin
    unique case (state_i)
      ST_COL, ST_DONE:         ma_o = col_q;
      ST_REF_RAS, ST_REF_DONE: ma_o = MA_W'(ref_row_i);
      default:                 ma_o = row_q;
    endcase
  end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int MA_W         = 9,
  parameter int BANKS        = 2,
  parameter int BANK_LSB     = 19,
  parameter int ROW_W        = 8,
  parameter int REF_INTERVAL = 780,
  parameter int T_ROW        = 2,
  parameter int T_COL        = 2,
  parameter int T_DONE       = 2,
  parameter int T_REF_RAS    = 3,
  parameter int T_REF_DONE   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wait_o,
  output logic              ack_o,
  output logic [MA_W-1:0]   ma_o,
  output logic [BANKS-1:0]  ras_n_o,
  output logic [BANKS-1:0]  cas_n_o,
  output logic              we_n_o
);
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  seq_state_e        state;
  logic              latch, ref_take, ref_done, ref_pend, we_q;
  logic [ROW_W-1:0]  ref_row;
  logic [BANK_W-1:0] bank;
  logic              acc_ras, acc_cas, ref_ras, ref_busy;

  dram_ref_timer #(
    .REF_INTERVAL(REF_INTERVAL),
    .ROW_W       (ROW_W)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(ref_take),
    .done_i(ref_done),
    .pend_o(ref_pend),
    .row_o (ref_row)
  );

  dram_seq_fsm #(
    .T_ROW     (T_ROW),
    .T_COL     (T_COL),
    .T_DONE    (T_DONE),
    .T_REF_RAS (T_REF_RAS),
    .T_REF_DONE(T_REF_DONE)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ref_pend_i(ref_pend),
    .state_o   (state),
    .latch_o   (latch),
    .ref_take_o(ref_take),
    .ref_done_o(ref_done),
    .ack_o     (ack_o)
  );

  dram_addr_mux #(
    .ADDR_W  (ADDR_W),
    .MA_W    (MA_W),
    .BANK_LSB(BANK_LSB),
    .BANK_W  (BANK_W),
    .ROW_W   (ROW_W)
  ) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .latch_i  (latch),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .state_i  (state),
    .ref_row_i(ref_row),
    .ma_o     (ma_o),
    .bank_o   (bank),
    .we_o     (we_q)
  );

  assign acc_ras  = (state == ST_ROW) || (state == ST_COL);
  assign acc_cas  = (state == ST_COL);
  assign ref_ras  = (state == ST_REF_RAS);
  assign ref_busy = ref_ras || (state == ST_REF_DONE);
  assign we_n_o   = !(acc_cas && we_q);
  assign wait_o   = ref_busy || (req_i && !ack_o);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic sel;
    assign sel        = (bank == BANK_W'(b));
    assign ras_n_o[b] = !((acc_ras && sel) || ref_ras);
    assign cas_n_o[b] = !(acc_cas && sel);

    assert_cas_under_ras_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cas_n_o[b] |-> !ras_n_o[b]);
  end

  assert_ras_only_refresh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_n_o == '0) |-> ((&cas_n_o) && we_n_o));
  assert_wait_in_refresh_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_n_o == '0) |-> wait_o);
  assert_single_bank_cas_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cas_n_o));
  assert_ack_no_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (!wait_o && (&ras_n_o) && (&cas_n_o)));
endmodule

// File: tb/dram_refresh_ctrl_tb.sv
module dram_refresh_ctrl_tb;
  localparam int REF_INTERVAL = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [19:0] addr = '0;
  logic        wait_s, ack;
  logic [8:0]  ma;
  logic [1:0]  ras_n, cas_n;
  logic        we_n;

  int tests = 0, fails = 0;
  int cyc = 0, ref_count = 0, ref_cyc_prev = 0, ref_cyc_last = 0;
  logic [8:0] last_ref_ma = '0;
  logic [1:0] prev_ras = 2'b11;
  bit finished = 0;

  always #10 clk = ~clk;

  dram_refresh_ctrl #(.REF_INTERVAL(REF_INTERVAL)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .we_i   (we),
    .addr_i (addr),
    .wait_o (wait_s),
    .ack_o  (ack),
    .ma_o   (ma),
    .ras_n_o(ras_n),
    .cas_n_o(cas_n),
    .we_n_o (we_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // refresh monitor: row sequence, RAS-only shape, spacing
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (ras_n == 2'b00 && prev_ras != 2'b00) begin
        check(ma == 9'(ref_count % 256), "R9 refresh row", ma, ref_count % 256);
        check(cas_n == 2'b11 && we_n, "R4 ras-only cycle", {cas_n, we_n}, 3'b111);
        check(wait_s, "R6 wait during refresh", wait_s, 1);
        last_ref_ma  = ma;
        ref_cyc_prev = ref_cyc_last;
        ref_cyc_last = cyc;
        ref_count++;
      end
      prev_ras = ras_n;
    end
  end

  task automatic run_access(input logic [19:0] a, input bit w, input bit keep);
    logic [8:0] er  = a[18:10];
    logic [8:0] ec  = a[9:1];
    logic [1:0] sel = a[19] ? 2'b01 : 2'b10;
    bit seen_row = 0, seen_col = 0;
    req = 1'b1; addr = a; we = w;
    forever begin
      @(negedge clk);
      if (ras_n != 2'b11 && ras_n != 2'b00 && !seen_row) begin
        seen_row = 1;
        check(ras_n == sel, "R5 row strobe bank", ras_n, sel);
        check(ma == er, "R1 row half", ma, er);
        check(cas_n == 2'b11, "R2 ras before cas", cas_n, 2'b11);
        check(wait_s, "R6 wait while pending", wait_s, 1);
      end
      if (cas_n != 2'b11 && !seen_col) begin
        seen_col = 1;
        check(cas_n == sel, "R5 column strobe bank", cas_n, sel);
        check(ras_n == sel, "R2 ras held under cas", ras_n, sel);
        check(ma == ec, "R1 column half", ma, ec);
        check(we_n == !w, "R3 write enable", we_n, !w);
      end
      if (ack) begin
        check(seen_row && seen_col, "R2 strobe order", {seen_row, seen_col}, 2'b11);
        check(!wait_s, "R6 wait low at ack", wait_s, 0);
        check(ras_n == 2'b11 && cas_n == 2'b11, "R2 strobes released", {ras_n, cas_n}, 4'hf);
        if (!keep) req = 1'b0;
        break;
      end
    end
    if (!keep) begin
      @(negedge clk);
      check(!ack, "R6 ack single cycle", ack, 0);
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(ras_n == 2'b11 && cas_n == 2'b11 && we_n, "R10 strobes in reset", {ras_n, cas_n, we_n}, 5'h1f);
    check(!wait_s && !ack, "R10 wait/ack in reset", {wait_s, ack}, 0);
    rst_n = 1'b1;
  endtask

  task automatic test_accesses();
    run_access(20'h2A5F6, 1'b0, 1'b0);  // bank 0 read
    run_access(20'hD3C0B, 1'b1, 1'b0);  // bank 1 write
    run_access(20'h7FFFE, 1'b1, 1'b0);  // bank 0 write, all-ones halves
    run_access(20'h80000, 1'b0, 1'b0);  // bank 1 read, zero halves
  endtask

  task automatic test_priority();
    int c0 = ref_count;
    wait (ref_count != c0);
    repeat (REF_INTERVAL - 4) @(negedge clk);
    c0 = ref_count;
    run_access(20'h15A34, 1'b0, 1'b1);
    check(ref_count == c0, "R7 no refresh inside access", ref_count, c0);
    addr = 20'h9B2C8; we = 1'b1;
    do @(negedge clk); while (ras_n == 2'b11);
    check(ras_n == 2'b00, "R7 refresh before waiting request", ras_n, 2'b00);
    check(wait_s, "R6 wait while refresh holds request", wait_s, 1);
    run_access(20'h9B2C8, 1'b1, 1'b0);
  endtask

  task automatic test_interval();
    int c0 = ref_count;
    wait (ref_count >= c0 + 3);
    check(ref_cyc_last - ref_cyc_prev == REF_INTERVAL, "R8 refresh spacing",
          ref_cyc_last - ref_cyc_prev, REF_INTERVAL);
  endtask

  task automatic test_wrap();
    wait (ref_count >= 256);
    wait (ref_count == 257);
    check(last_ref_ma == 9'd0, "R9 row wrap to 0", last_ref_ma, 0);
    wait (ref_count == 258);
    check(last_ref_ma == 9'd1, "R9 row after wrap", last_ref_ma, 1);
  endtask

  initial begin
    test_reset();
    test_accesses();
    test_priority();
    test_interval();
    test_wrap();
    run_access(20'h4C3A2, 1'b1, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule